// File: doc/BRIEF.md
# Power-Fail Byte-Lane SRAM Chip-Enable Gate

This block drives the chip enables of one or two external SRAMs that share a 16-bit data bus. The host gives one active-low chip-enable strobe and two active-low byte-lane enables. From these the block produces one active-low enable for the memory on the lower data half (D7–D0) and one for the memory on the upper data half (D15–D8). Word accesses, upper-byte accesses and lower-byte accesses all come from the same three inputs.

The block also write-protects the memories while the supply is not good. When the supply-good input falls, both enables are forced inactive at once, through logic only and with no clock delay. When the supply returns, a recovery timer keeps access blocked for a set number of clock cycles. The count starts again if the supply drops before it ends. Access is also blocked after reset, as if power had just come up. A protect output reports when either cause is blocking access.

Top module: `psg_gate`

## Requirements
- R1: With ce_in_n, bhe_n and ble_n all low, and access not blocked, ce_lo_n and ce_hi_n are both low (word transfer).
- R2: With ce_in_n low, bhe_n low and ble_n high, and access not blocked, only ce_hi_n (the upper half, D15–D8) is low.
- R3: With ce_in_n low, bhe_n high and ble_n low, and access not blocked, only ce_lo_n (the lower half, D7–D0) is low.
- R4: ce_lo_n and ce_hi_n are both high whenever ce_in_n is high, or when bhe_n and ble_n are both high.
- R5: While supply_ok is low, ce_lo_n and ce_hi_n are high for every input pattern. This forcing is combinational and needs no clock edge.
- R6: After supply_ok rises and then stays high, protect falls on the SYNC_STAGES + RECOVER_CYCLES-th rising clock edge, counting the first edge after the rise as edge one. Until then both enables stay high. Release happens only on a clock edge.
- R7: protect is high whenever supply_ok is low or the recovery interval has not finished, and it is low otherwise.
- R8: If supply_ok drops while the recovery count is running, the count starts again. The interval is then measured from the latest rise.
- R9: While rst_n is low, and after rst_n is released, protect is high and both enables are high until a full recovery interval has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the recovery timer |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ce_in_n | input | 1 | Active-low chip-enable strobe from the host |
| bhe_n | input | 1 | Active-low upper-byte-lane enable |
| ble_n | input | 1 | Active-low lower-byte-lane enable |
| supply_ok | input | 1 | High while the supply is above the power-fail threshold |
| ce_lo_n | output | 1 | Active-low enable for the SRAM on D7–D0 |
| ce_hi_n | output | 1 | Active-low enable for the SRAM on D15–D8 |
| protect | output | 1 | High while access is blocked by a power fail or by recovery |

## Verification
The bench builds the block with RECOVER_CYCLES = 8 and SYNC_STAGES = 2. With these values the exact edge on which protect releases can be checked within a short run, on both sides of that edge. A restart that begins halfway through the count is also easy to reach, and the edge on which an uninterrupted count would have ended can be shown to still be blocked. The default interval of several thousand cycles uses the same counter logic with a wider count.

// File: rtl/psg_pkg.sv
package psg_pkg;
  typedef enum logic [1:0] {
    LANE_NONE = 2'b00,
    LANE_LOW  = 2'b01,
    LANE_HIGH = 2'b10,
    LANE_WORD = 2'b11
  } lane_sel_e;
endpackage

// File: rtl/psg_sync.sv
module psg_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/psg_lane_decode.sv
module psg_lane_decode
  import psg_pkg::*;
(
  input  logic ce_in_n,
  input  logic bhe_n,
  input  logic ble_n,
  input  logic block,
  output logic ce_lo_n,
  output logic ce_hi_n
);
  lane_sel_e lane;

  always_comb begin
    if (ce_in_n) begin
      lane = LANE_NONE;
    end else begin
      unique case ({bhe_n, ble_n})
        2'b00:   lane = LANE_WORD;
        2'b01:   lane = LANE_HIGH;
        2'b10:   lane = LANE_LOW;
        default: lane = LANE_NONE;
      endcase
    end
  end

  always_comb begin
    ce_lo_n = 1'b1;
    ce_hi_n = 1'b1;
    if (!block) begin
      ce_lo_n = !(lane == LANE_LOW  || lane == LANE_WORD);
      ce_hi_n = !(lane == LANE_HIGH || lane == LANE_WORD);
    end
  end
endmodule

// File: rtl/psg_recovery_timer.sv
module psg_recovery_timer #(
  parameter int RECOVER_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ok_sync,
  output logic lockout
);
  localparam int CW = (RECOVER_CYCLES > 1) ? $clog2(RECOVER_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(RECOVER_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lock_q, lock_d;
  logic          cnt_en;

  assign cnt_en = lock_q && ok_sync;

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (!ok_sync) begin
      cnt_d  = '0;
      lock_d = 1'b1;
    end else if (cnt_en) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        lock_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign lockout = lock_q;
endmodule

// File: rtl/psg_gate.sv
module psg_gate #(
  parameter int RECOVER_CYCLES = 5000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  input  logic bhe_n,
  input  logic ble_n,
  input  logic supply_ok,
  output logic ce_lo_n,
  output logic ce_hi_n,
  output logic protect
);
  logic rst_n_int;
  logic ok_sync;
  logic lockout;
  logic block;

  psg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_int)
  );

  psg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ok_sync (
    .clk(clk), .rst_n(rst_n_int), .d(supply_ok), .q(ok_sync)
  );

  psg_recovery_timer #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n_int), .ok_sync(ok_sync), .lockout(lockout)
  );

  assign block = !supply_ok || lockout;

  psg_lane_decode u_decode (
    .ce_in_n(ce_in_n), .bhe_n(bhe_n), .ble_n(ble_n), .block(block),
    .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n)
  );

  assign protect = block;
endmodule

// File: rtl/psg_gate_chk.sv
module psg_gate_chk #(
  parameter int RECOVER_CYCLES = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic ce_in_n,
  input logic bhe_n,
  input logic ble_n,
  input logic supply_ok,
  input logic ce_lo_n,
  input logic ce_hi_n,
  input logic protect
);
  int unsigned ok_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ok_run <= 0;
    else if (!supply_ok)             ok_run <= 0;
    else if (ok_run < 32'h7fff_ffff) ok_run <= ok_run + 1;
  end

  p_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!protect && !ce_in_n && !bhe_n && !ble_n) |-> (!ce_lo_n && !ce_hi_n));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_in_n || (bhe_n && ble_n)) |-> (ce_lo_n && ce_hi_n));

  p_fail_forces_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (ce_lo_n && ce_hi_n));

  p_no_early_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !protect |-> (ok_run >= RECOVER_CYCLES));

  p_protect_on_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> protect);

  p_blocked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    protect |-> (ce_lo_n && ce_hi_n));

  p_release_needs_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protect) |-> $past(supply_ok));
endmodule

bind psg_gate psg_gate_chk #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .bhe_n(bhe_n), .ble_n(ble_n),
  .supply_ok(supply_ok), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .protect(protect)
);

// File: tb/psg_gate_bench.sv
module psg_gate_bench;
  localparam int RC = 8;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst_n, ce_in_n, bhe_n, ble_n, supply_ok;
  logic ce_lo_n, ce_hi_n, protect;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  psg_gate #(.RECOVER_CYCLES(RC), .SYNC_STAGES(SS)) u_psg_gate (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .bhe_n(bhe_n), .ble_n(ble_n),
    .supply_ok(supply_ok), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .protect(protect)
  );

  // {ce_in_n, bhe_n, ble_n, exp ce_lo_n, exp ce_hi_n}
  localparam logic [4:0] VEC [8] = '{
    5'b000_00,  // R1 word
    5'b001_10,  // R2 upper byte
    5'b010_01,  // R3 lower byte
    5'b011_11,  // R4 both lanes off
    5'b100_11,  // R4 strobe high
    5'b101_11,  // R4
    5'b110_11,  // R4
    5'b111_11   // R4
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (ce_lo_n,ce_hi_n,protect)", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [2:0] v);
    {ce_in_n, bhe_n, ble_n} = v;
    #1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b1;
    {ce_in_n, bhe_n, ble_n} = 3'b000;
    edges(3);
    check("R9 in reset", {ce_lo_n, ce_hi_n, protect}, 3'b111);
    @(negedge clk); rst_n = 1'b1;
    edges(2);
    check("R9 after release", {ce_lo_n, ce_hi_n, protect}, 3'b111);
    edges(3 * RC);
    check("R9 recovered", {ce_lo_n, ce_hi_n, protect}, 3'b000);

    // vector table with access open
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      drive(VEC[k][4:2]);
      check($sformatf("R1-4 vec%0d", k), {ce_lo_n, ce_hi_n, protect}, {VEC[k][1:0], 1'b0});
    end

    // R5/R7: combinational forcing, all patterns
    @(negedge clk);
    drive(3'b000);
    supply_ok = 1'b0; #1;
    check("R5 immediate", {ce_lo_n, ce_hi_n, protect}, 3'b111);
    for (int k = 0; k < 8; k++) begin
      drive(VEC[k][4:2]);
      check("R5 any pattern", {ce_lo_n, ce_hi_n, protect}, 3'b111);
    end
    drive(3'b000);
    edges(4);
    check("R7 low supply", {ce_lo_n, ce_hi_n, protect}, 3'b111);

    // R6 exact release edge
    @(negedge clk); supply_ok = 1'b1;
    edges(SS + RC - 1);
    check("R6 before edge", {ce_lo_n, ce_hi_n, protect}, 3'b111);
    edges(1);
    check("R6 release edge", {ce_lo_n, ce_hi_n, protect}, 3'b000);
    @(negedge clk); drive(3'b001);
    check("R2 after recovery", {ce_lo_n, ce_hi_n, protect}, 3'b100);
    drive(3'b000);

    // R8 restart mid-count
    @(negedge clk); supply_ok = 1'b0;
    edges(4);
    @(negedge clk); supply_ok = 1'b1;
    edges(4);
    @(negedge clk); supply_ok = 1'b0; #1;
    check("R8 drop mid-count", {ce_lo_n, ce_hi_n, protect}, 3'b111);
    @(negedge clk); supply_ok = 1'b1;
    edges(SS + RC - 5);
    check("R8 old deadline blocked", {ce_lo_n, ce_hi_n, protect}, 3'b111);
    edges(4);
    check("R8 before new edge", {ce_lo_n, ce_hi_n, protect}, 3'b111);
    edges(1);
    check("R8 new release edge", {ce_lo_n, ce_hi_n, protect}, 3'b000);
    @(negedge clk); drive(3'b010);
    check("R3 after restart", {ce_lo_n, ce_hi_n, protect}, 3'b010);

    // R9 reset mid-operation blocks again
    @(negedge clk); rst_n = 1'b0; #1;
    check("R9 reset blocks", {ce_lo_n, ce_hi_n, protect}, 3'b111);
    @(negedge clk); rst_n = 1'b1;
    edges(SS + 1);
    check("R9 still blocked", {ce_lo_n, ce_hi_n, protect}, 3'b111);
    edges(3 * RC);
    check("R3 open again", {ce_lo_n, ce_hi_n, protect}, 3'b010);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule